// File: doc/BRIEF.md
# Two-Step Flash Code Combiner

This block is the digital back end of a subranging 8-bit converter. The analog front end offers two banks of 15 comparators. The first bank resolves the upper nibble and the second bank resolves the lower nibble inside the subrange that the first bank picked. An external sequencer presents the first-bank thermometer word with a `load_coarse` strobe. It presents the second-bank word one phase later with `load_fine`. A `correct` strobe then releases the joined code. The block stores both raw words and repairs isolated comparator bubbles with a three-input majority vote. It converts each repaired word to a 4-bit count of tripped comparators and registers the 8-bit offset-binary result.

The repaired upper nibble is also driven out continuously on `coarse_code`. The external subrange selector uses it to pick the fine ladder segment before the second bank fires. The code is offset binary about a mid-scale centre. All zeros is negative full scale. `8'h80` is the bipolar zero. `8'hFF` is one LSB below positive full scale. The top bit is therefore the sign: it is 1 when eight or more first-bank comparators tripped.

The result port is a plain data port with a one-cycle `result_valid` qualifier. It has no ready input and accepts no back-pressure. The consumer must take the code in the cycle that `result_valid` is high. The result is still held on the port until the next `correct` strobe.

Top module: `two_step_combiner`

## Requirements
- R1: After reset, `result` is 0, `result_valid` is 0 and `coarse_code` is 0.
- R2: One cycle after `load_coarse`, `coarse_code` equals the number of ones in the repaired first-bank word (0 to 15). Without `load_coarse`, `coarse_code` does not change.
- R3: The low four bits of the result equal the number of ones in the repaired second-bank word that was captured by the last `load_fine`.
- R4: The result is coarse count × 16 + fine count, which is offset binary. The most significant bit is 1 exactly when the coarse count is 8 or more, and a coarse count of 8 with a fine count of 0 gives 8'h80.
- R5: A `correct` strobe registers the result. `result_valid` is high in the following cycle only, so one strobe gives one pulse.
- R6: Between `correct` strobes, `result` holds its value and `result_valid` stays low, even while new words are loaded.
- R7: An isolated 0 with ones on both sides is filled before counting. For example, word 15'h00DF counts as 8.
- R8: An isolated 1 with zeros on both sides is removed before counting. Below bit 0 the word is taken as 1 and above bit 14 as 0. So 15'h4007 counts as 3 and 15'h0002 counts as 1.
- R9: A clean thermometer word (ones only in a contiguous run from bit 0) passes the repair unchanged. The all-zero pair gives 8'h00 and the all-ones pair gives 8'hFF.
- R10: When `correct` coincides with `load_coarse` or `load_fine`, the result uses the words that were stored before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coarse_therm | input | 15 | First-bank comparator thermometer word |
| load_coarse | input | 1 | Capture `coarse_therm` |
| fine_therm | input | 15 | Second-bank comparator thermometer word |
| load_fine | input | 1 | Capture `fine_therm` |
| correct | input | 1 | Release the joined, repaired code |
| coarse_code | output | 4 | Repaired first-bank count for the subrange selector |
| result | output | 8 | Offset-binary conversion result |
| result_valid | output | 1 | One-cycle qualifier for a new `result` |

## Verification
The assertions check three things on every cycle. Any clean thermometer leaves the bubble repair unchanged. `result` and `coarse_code` move only after their strobes. A freshly released result carries the current coarse count in its upper nibble. Only the bench scenarios can show the arithmetic of the joined code, the sign boundary at 8'h80, and the full-scale extremes. The same holds for the exact fill and removal of bubbles at the word edges, the single-cycle valid pulse, and the use of old words when a load coincides with `correct`.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int THERM_W = 15;
  localparam int NIB_W   = $clog2(THERM_W + 1);
  localparam int RES_W   = 2 * NIB_W;
endpackage

// File: rtl/tsc_bubble_fix.sv
module tsc_bubble_fix #(
  parameter int W = 15
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] clean
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // Each output is a majority of the bit and its two neighbours.
  // Below the lowest comparator counts as tripped and above the top as idle.
  for (genvar i = 0; i < W; i++) begin : g_vote
    logic lo, hi;
    if (i == 0) begin : g_bot
      assign lo = 1'b1;
    end else begin : g_lo
      assign lo = raw[i-1];
    end
    if (i == W - 1) begin : g_top
      assign hi = 1'b0;
    end else begin : g_hi
      assign hi = raw[i+1];
    end
    assign clean[i] = (lo & raw[i]) | (lo & hi) | (raw[i] & hi);
  end

  // R9
  always_comb begin
    if ((raw & (raw + ONE)) == '0) begin
      therm_keep_chk: assert (clean == raw);
    end
  end
endmodule

// File: rtl/tsc_popcount.sv
module tsc_popcount #(
  parameter int W  = 15,
  parameter int OW = 4
) (
  input  logic [W-1:0]  bits,
  output logic [OW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + {{(OW-1){1'b0}}, bits[i]};
    end
  end
endmodule

// File: rtl/two_step_combiner.sv
module two_step_combiner
  import tsc_pkg::*;
#(
  parameter int TW = THERM_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TW-1:0]                 coarse_therm,
  input  logic                          load_coarse,
  input  logic [TW-1:0]                 fine_therm,
  input  logic                          load_fine,
  input  logic                          correct,
  output logic [$clog2(TW+1)-1:0]       coarse_code,
  output logic [2*$clog2(TW+1)-1:0]     result,
  output logic                          result_valid
);
  localparam int NW = $clog2(TW + 1);
  localparam int RW = 2 * NW;

  logic [TW-1:0] coarse_raw_q, fine_raw_q;
  logic [TW-1:0] coarse_fix, fine_fix;
  logic [NW-1:0] coarse_nib, fine_nib;
  logic [RW-1:0] result_q;
  logic          valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse_raw_q <= '0;
      fine_raw_q   <= '0;
      result_q     <= '0;
      valid_q      <= 1'b0;
    end else begin
      if (load_coarse) coarse_raw_q <= coarse_therm;
      if (load_fine)   fine_raw_q   <= fine_therm;
      if (correct)     result_q     <= {coarse_nib, fine_nib};
      valid_q <= correct;
    end
  end

  tsc_bubble_fix #(.W(TW)) u_fix_coarse (.raw(coarse_raw_q), .clean(coarse_fix));
  tsc_bubble_fix #(.W(TW)) u_fix_fine   (.raw(fine_raw_q),   .clean(fine_fix));
  tsc_popcount #(.W(TW), .OW(NW)) u_cnt_coarse (.bits(coarse_fix), .count(coarse_nib));
  tsc_popcount #(.W(TW), .OW(NW)) u_cnt_fine   (.bits(fine_fix),   .count(fine_nib));

  assign coarse_code  = coarse_nib;
  assign result       = result_q;
  assign result_valid = valid_q;

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(correct) |-> ($stable(result) && !result_valid));

  // R2
  coarse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_coarse) |-> $stable(coarse_code));

  // R4
  result_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !$past(load_coarse)) |-> (result[RW-1 -: NW] == coarse_code));
endmodule

// File: tb/two_step_combiner_tb_top.sv
module two_step_combiner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] coarse_therm = '0;
  logic        load_coarse = 1'b0;
  logic [14:0] fine_therm = '0;
  logic        load_fine = 1'b0;
  logic        correct = 1'b0;
  logic [3:0]  coarse_code;
  logic [7:0]  result;
  logic        result_valid;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_exp = 8'h00;

  always #4 clk = ~clk;

  two_step_combiner dut_i (
    .clk(clk), .rst_n(rst_n),
    .coarse_therm(coarse_therm), .load_coarse(load_coarse),
    .fine_therm(fine_therm), .load_fine(load_fine),
    .correct(correct),
    .coarse_code(coarse_code), .result(result), .result_valid(result_valid)
  );

  function automatic logic [14:0] lvl(int n);
    return 15'((32'd1 << n) - 1);
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Monitor: pops expected codes whenever a result is released (R5, R4).
  always @(negedge clk) begin
    if (rst_n && result_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected valid", 16'(result), 16'h0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(result == e, "R4 result", 16'(result), 16'(e));
      end
    end
  end

  // Driver: one full conversion, coarse then fine then correct.
  task automatic conv(logic [14:0] c, logic [14:0] f, logic [7:0] e, string req);
    @(negedge clk);
    coarse_therm = c; load_coarse = 1'b1;
    @(negedge clk);
    load_coarse = 1'b0;
    check(coarse_code == e[7:4], req, 16'(coarse_code), 16'(e[7:4]));
    fine_therm = f; load_fine = 1'b1;
    @(negedge clk);
    load_fine = 1'b0; correct = 1'b1;
    exp_q.push_back(e);
    last_exp = e;
    @(negedge clk);
    correct = 1'b0;
    @(negedge clk);
    // R5 single pulse, R6 hold
    check(!result_valid && result == e, "R5 pulse/hold", {7'd0, result_valid, result}, 16'(e));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 16'h0, 16'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(result == 8'h00 && !result_valid && coarse_code == 4'h0, "R1 reset",
          {3'd0, result_valid, coarse_code, result}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(result == 8'h00 && !result_valid, "R1 after release", 16'(result), 16'h0);

    conv(lvl(8),  lvl(0),  8'h80, "R4 zero R2");
    conv(lvl(0),  lvl(0),  8'h00, "R9 min R2");
    conv(lvl(15), lvl(15), 8'hFF, "R9 max R2");
    conv(lvl(7),  lvl(15), 8'h7F, "R4 below zero R3");
    conv(lvl(3),  lvl(9),  8'h39, "R3 mid R2");
    conv(15'h00DF, lvl(2), 8'h82, "R7 fill coarse");
    conv(lvl(5), 15'h4007, 8'h53, "R8 top lone one fine");
    conv(15'h0002, lvl(4), 8'h14, "R8 bottom edge coarse");
    conv(lvl(1), 15'h0077, 8'h17, "R7 fill fine");

    // R6: new loads without correct leave result alone.
    @(negedge clk);
    coarse_therm = lvl(12); load_coarse = 1'b1;
    fine_therm = lvl(6); load_fine = 1'b1;
    @(negedge clk);
    load_coarse = 1'b0; load_fine = 1'b0;
    @(negedge clk);
    check(result == last_exp && !result_valid, "R6 hold on load", 16'(result), 16'(last_exp));
    check(coarse_code == 4'd12, "R2 code after load", 16'(coarse_code), 16'd12);

    // R10: correct together with new loads uses stored words (12, 6).
    coarse_therm = lvl(2); load_coarse = 1'b1;
    fine_therm = lvl(1); load_fine = 1'b1;
    correct = 1'b1;
    exp_q.push_back(8'hC6);
    @(negedge clk);
    load_coarse = 1'b0; load_fine = 1'b0; correct = 1'b0;
    check(result == 8'hC6, "R10 old words", 16'(result), 16'hC6);
    check(coarse_code == 4'd2, "R10 coarse reloaded", 16'(coarse_code), 16'd2);
    @(negedge clk);
    check(!result_valid && result == 8'hC6, "R5 one pulse", {7'd0, result_valid, result}, 16'hC6);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R5 all released", 16'(exp_q.size()), 16'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule